// File: doc/BRIEF.md
# Watchdog Reset Controller

An 8-bit watchdog counter with a reset control and status register. Software starts the counter through a small control register and must keep restarting it before it wraps. When the counter steps from 0xFF to 0x00 in watchdog mode, the block records a sticky overflow flag. If resets are enabled, it also drives a fixed-length internal reset pulse. The counter and its control register always return to their idle values on such an overflow. The status register is restored only by the external reset.

In interval mode the same counter runs freely. Each wrap raises a one-cycle interrupt request and never touches the flag or the reset output. Counting advances only on cycles where the tick input is high, so a prescaler outside the block sets the rate.

The status register is guarded by a key byte in the upper half of every 16-bit write. Clearing the flag is a two-step handshake: a read that sees the flag set, followed by a keyed write of 0 to that bit.

Top module: `wdt_reset_ctrl`

## Requirements
- R1: After the external reset the status register (address 1) reads 0x1F, the control register (address 0) reads 0x00, the counter (address 2) reads 0, and both the reset output and the interrupt output are low.
- R2: The control register holds bit 1 = mode (1 watchdog, 0 interval) and bit 0 = run. While run is 1, the counter advances by one on every cycle with the tick input high and holds otherwise. Writing the control register with bit 0 = 0 stops the counter and clears it to 0.
- R3: Status bit 7 is the overflow flag. It becomes 1 when the counter wraps from 0xFF to 0x00 in watchdog mode.
- R4: In interval mode a wrap never sets the flag and never drives the reset output. Instead, the interrupt output is high for exactly the one cycle after the wrap, and the counter continues from 0.
- R5: The flag clears only on a status write with key byte 0xA5 and data bit 7 = 0 that follows a status read which saw the flag at 1. A keyed write with bit 7 = 1, or one with no such prior read, leaves the flag set.
- R6: Status bit 6 is the reset enable, loaded from data bit 6 by a status write with key byte 0x5A. With it set, a watchdog-mode wrap drives the reset output high from the next cycle for exactly PULSE_LEN cycles.
- R7: On a watchdog-mode wrap the counter and the control register return to 0 whatever the reset enable is. With the reset enable at 0, the reset output stays low.
- R8: The status register (flag and reset enable) keeps its value through the watchdog's own overflow and reset pulse. Only the external reset brings it back to 0x1F.
- R9: A status write whose key byte is neither 0x5A nor 0xA5 leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| extRstN | input | 1 | External reset, active low, asynchronous |
| countTick | input | 1 | Count enable from an outside prescaler |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 2 | Register select: 0 control, 1 status, 2 counter |
| busWrData | input | 16 | Write data; the upper byte is the key for status writes |
| busRdData | output | 8 | Read data of the selected register |
| intRstOut | output | 1 | Internal reset pulse to the chip |
| intervalIrq | output | 1 | One-cycle interval-mode interrupt request |

## Verification
The bench builds the block with PULSE_LEN set to 6 and the default 8-bit counter and keys. This lets it count every cycle of the reset pulse, including the first cycle after the pulse ends, within a few cycles of the wrap. Keeping the full 8-bit counter means each wrap really needs 256 ticks. The seeded random runs of tick bursts in interval mode therefore cross the 0xFF boundary several times, and the bench compares the interrupt count against its own model of the counter.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic ctrlLoad;
    logic newMode;
    logic newRun;
    logic wdClear;
  } wdtStrobe_t;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             extRstN,
  input  logic             countTick,
  input  wdtStrobe_t       strobe,
  output logic [CNT_W-1:0] cnt,
  output logic             modeWd,
  output logic             run,
  output logic             wrap
);

  logic step;
  assign step = run && countTick;
  assign wrap = step && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN) begin
      cnt    <= '0;
      modeWd <= 1'b0;
      run    <= 1'b0;
    end else if (strobe.wdClear) begin
      cnt    <= '0;
      modeWd <= 1'b0;
      run    <= 1'b0;
    end else if (strobe.ctrlLoad) begin
      modeWd <= strobe.newMode;
      run    <= strobe.newRun;
      if (!strobe.newRun) cnt <= '0;
      else if (step)      cnt <= cnt + 1'b1;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_WD_CLEAR: assert property (@(posedge clk) disable iff (!extRstN)
    strobe.wdClear |=> (cnt == '0) && !run && !modeWd); // R7
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!extRstN)
    strobe.ctrlLoad && !strobe.newRun && !strobe.wdClear |=> cnt == '0); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!extRstN)
    step && !strobe.ctrlLoad && !strobe.wdClear |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!extRstN)
    !countTick && !strobe.ctrlLoad && !strobe.wdClear |=> $stable(cnt)); // R2

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int         CNT_W     = 8,
  parameter int         PULSE_LEN = 16,
  parameter logic [7:0] KEY_EN    = 8'h5A,
  parameter logic [7:0] KEY_CLR   = 8'hA5
) (
  input  logic             clk,
  input  logic             extRstN,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [1:0]       busAddr,
  input  logic [15:0]      busWrData,
  output logic [7:0]       busRdData,
  input  logic [CNT_W-1:0] cnt,
  input  logic             modeWd,
  input  logic             run,
  input  logic             wrap,
  output wdtStrobe_t       strobe,
  output logic             intRstOut,
  output logic             intervalIrq
);

  localparam int PCNT_W = $clog2(PULSE_LEN + 1);

  logic [7:0]        keyByte;
  logic              wdOvf, statWr, enWr, clrWr, statRd;
  logic              flag, rstEn, readArmed, irqQ;
  logic [PCNT_W-1:0] pulseCnt;
  logic              unusedWrBits;

  assign keyByte      = busWrData[15:8];
  assign unusedWrBits = ^busWrData[5:2];
  assign wdOvf        = wrap && modeWd;
  assign statWr       = busWrEn && (busAddr == ADDR_STAT);
  assign statRd       = busRdEn && (busAddr == ADDR_STAT);
  assign enWr         = statWr && (keyByte == KEY_EN);
  assign clrWr        = statWr && (keyByte == KEY_CLR) && !busWrData[7] && readArmed;

  always_comb begin
    strobe.wdClear  = wdOvf;
    strobe.ctrlLoad = busWrEn && (busAddr == ADDR_CTRL);
    strobe.newMode  = busWrData[1];
    strobe.newRun   = busWrData[0];
  end

  // status register: only the external reset touches it
  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN) begin
      flag      <= 1'b0;
      rstEn     <= 1'b0;
      readArmed <= 1'b0;
      pulseCnt  <= '0;
      irqQ      <= 1'b0;
    end else begin
      if (wdOvf)      flag <= 1'b1;
      else if (clrWr) flag <= 1'b0;

      if (clrWr)                readArmed <= 1'b0;
      else if (statRd && flag)  readArmed <= 1'b1;

      if (enWr) rstEn <= busWrData[6];

      if (wdOvf && rstEn)        pulseCnt <= PCNT_W'(PULSE_LEN);
      else if (pulseCnt != '0)   pulseCnt <= pulseCnt - 1'b1;

      irqQ <= wrap && !modeWd;
    end
  end

  assign intRstOut   = (pulseCnt != '0);
  assign intervalIrq = irqQ;

  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRdData = {6'b0, modeWd, run};
      ADDR_STAT: busRdData = {flag, rstEn, 1'b0, 5'h1F};
      ADDR_CNT:  busRdData = 8'(cnt);
      default:   busRdData = 8'h00;
    endcase
  end

  AST_FLAG_SET_WD: assert property (@(posedge clk) disable iff (!extRstN)
    $rose(flag) |-> $past(wrap && modeWd)); // R3
  AST_NO_FLAG_INTERVAL: assert property (@(posedge clk) disable iff (!extRstN)
    wrap && !modeWd && !flag |=> !flag); // R4
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!extRstN)
    intervalIrq |=> !intervalIrq); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!extRstN)
    flag && !clrWr |=> flag); // R5
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!extRstN)
    wdOvf && rstEn |=> intRstOut); // R6
  AST_NO_RST_DISABLED: assert property (@(posedge clk) disable iff (!extRstN)
    wdOvf && !rstEn && !intRstOut |=> !intRstOut); // R7
  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!extRstN)
    statWr && keyByte != KEY_EN && keyByte != KEY_CLR |=> $stable(rstEn) && $stable(flag)); // R9

endmodule

// File: rtl/wdt_reset_ctrl.sv
module wdt_reset_ctrl
  import wdt_pkg::*;
#(
  parameter int         CNT_W     = 8,
  parameter int         PULSE_LEN = 16,
  parameter logic [7:0] KEY_EN    = 8'h5A,
  parameter logic [7:0] KEY_CLR   = 8'hA5
) (
  input  logic        clk,
  input  logic        extRstN,
  input  logic        countTick,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [1:0]  busAddr,
  input  logic [15:0] busWrData,
  output logic [7:0]  busRdData,
  output logic        intRstOut,
  output logic        intervalIrq
);

  wdtStrobe_t       strobe;
  logic [CNT_W-1:0] cnt;
  logic             modeWd, run, wrap;

  wdt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .extRstN(extRstN), .countTick(countTick), .strobe(strobe),
    .cnt(cnt), .modeWd(modeWd), .run(run), .wrap(wrap)
  );

  wdt_ctrl #(
    .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN), .KEY_EN(KEY_EN), .KEY_CLR(KEY_CLR)
  ) u_ctrl (
    .clk(clk), .extRstN(extRstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .cnt(cnt), .modeWd(modeWd), .run(run), .wrap(wrap), .strobe(strobe),
    .intRstOut(intRstOut), .intervalIrq(intervalIrq)
  );

endmodule

// File: tb/wdt_reset_ctrl_tb.sv
module wdt_reset_ctrl_tb;

  localparam int PULSE = 6;

  logic        clk = 1'b0;
  logic        extRstN = 1'b0;
  logic        countTick = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWrData = 16'h0;
  logic [7:0]  busRdData;
  logic        intRstOut, intervalIrq;

  int tests = 0;
  int fails = 0;
  int irqCount = 0;
  int rstSeen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_reset_ctrl #(.PULSE_LEN(PULSE)) u_dut (
    .clk(clk), .extRstN(extRstN), .countTick(countTick), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .intRstOut(intRstOut), .intervalIrq(intervalIrq)
  );

  always @(negedge clk) begin
    if (intervalIrq) irqCount++;
    if (intRstOut)   rstSeen++;
  end

  task automatic check(input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      countTick = 1'b1;
      @(negedge clk);
    end
    countTick = 1'b0;
  endtask

  function automatic logic [7:0] statVal(input bit f, input bit en);
    return {f, en, 1'b0, 5'h1F};
  endfunction

  function automatic int wrapsOf(input int start, input int n);
    return (start + n) / 256;
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all R): actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int expCnt, expIrq, hi, n;
    bit firstHi;
    void'($urandom(32'h1234_5678));

    repeat (3) @(negedge clk);
    extRstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd1, d); check("R1 status after reset", d, 8'h1F);
    rd(2'd0, d); check("R1 control after reset", d, 8'h00);
    rd(2'd2, d); check("R1 counter after reset", d, 0);
    check("R1 reset output", intRstOut, 0);
    check("R1 interrupt output", intervalIrq, 0);

    // R2 counting, holding, stop clears
    wr(2'd0, 16'h0001);
    ticks(10);
    rd(2'd2, d); check("R2 counter after 10 ticks", d, 10);
    repeat (3) @(negedge clk);
    rd(2'd2, d); check("R2 counter holds without tick", d, 10);
    wr(2'd0, 16'h0000);
    rd(2'd2, d); check("R2 stop clears counter", d, 0);

    // R4 random interval-mode bursts
    wr(2'd0, 16'h0001);
    expCnt = 0; expIrq = 0; irqCount = 0; rstSeen = 0;
    for (int i = 0; i < 30; i++) begin
      n = $urandom_range(0, 60);
      ticks(n);
      expIrq += wrapsOf(expCnt, n);
      expCnt = (expCnt + n) % 256;
      rd(2'd2, d); check("R2 random interval count", d, expCnt);
    end
    check("R4 interrupt count over random run", irqCount, expIrq);
    rd(2'd1, d); check("R4 no flag in interval mode", d, 8'h1F);
    check("R4 no reset in interval mode", rstSeen, 0);

    // R4 directed: single-cycle interrupt at wrap
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0001);
    ticks(255);
    ticks(1);
    check("R4 interrupt the cycle after wrap", intervalIrq, 1);
    @(negedge clk);
    check("R4 interrupt drops after one cycle", intervalIrq, 0);
    rd(2'd2, d); check("R4 counter continues from 0", d, 0);
    rd(2'd0, d); check("R4 control kept in interval mode", d, 8'h01);

    // R9 wrong keys ignored
    for (int i = 0; i < 6; i++) begin
      logic [7:0] k;
      k = 8'($urandom);
      if (k == 8'h5A || k == 8'hA5) k = 8'h00;
      wr(2'd1, {k, 8'($urandom)});
      rd(2'd1, d); check("R9 bad key leaves status", d, 8'h1F);
    end

    // R7 watchdog overflow with reset disabled
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0003);
    ticks(255);
    rd(2'd2, d); check("R2 counter at 0xFF", d, 8'hFF);
    rstSeen = 0;
    ticks(1);
    repeat (PULSE + 2) @(negedge clk);
    check("R7 no reset pulse when disabled", rstSeen, 0);
    // R5 clear without a prior read is refused
    wr(2'd1, 16'hA500);
    rd(2'd0, d); check("R7 control returned to 0", d, 8'h00);
    rd(2'd2, d); check("R7 counter returned to 0", d, 0);
    rd(2'd1, d); check("R3/R5 flag set, unread clear refused", d, statVal(1, 0));
    wr(2'd1, 16'hA580);
    rd(2'd1, d); check("R5 writing 1 does not clear", d, statVal(1, 0));
    wr(2'd1, 16'hA500);
    rd(2'd1, d); check("R5 read then zero write clears", d, statVal(0, 0));

    // R6 reset enable and pulse length
    wr(2'd1, 16'h5A40);
    rd(2'd1, d); check("R6 enable written with key", d, statVal(0, 1));
    wr(2'd0, 16'h0003);
    ticks(255);
    ticks(1);
    hi = 0; firstHi = intRstOut;
    for (int i = 0; i < PULSE + 3; i++) begin
      if (intRstOut) hi++;
      @(negedge clk);
    end
    check("R6 reset starts next cycle", firstHi, 1);
    check("R6 reset pulse length", hi, PULSE);
    check("R6 reset released", intRstOut, 0);
    rd(2'd1, d); check("R8 status survives own reset", d, statVal(1, 1));
    rd(2'd0, d); check("R7 control cleared by overflow", d, 8'h00);

    // R8 external reset restores status
    extRstN = 1'b0;
    @(negedge clk);
    extRstN = 1'b1;
    @(negedge clk);
    rd(2'd1, d); check("R8 external reset restores status", d, 8'h1F);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule